// File: doc/BRIEF.md
# Per-CPU Interrupt Pending and Enable Controller

This block holds, for each of `NCPU` processors, a 32-bit pending word and a 32-bit enable word. It also holds one system-wide word for interrupt sources that may be taken by any processor. Each processor's enable word is rebuilt on request from that processor's status-word control bits and from the images of its control registers 0 and 14. Sources that belong to one processor are set and cleared directly in that processor's pending word. A shared source is recorded once in the system word and copied to every processor that is marked as started.

Program-event-recording (PER) bits run the other way round. Loading the CR9 image writes the selected events into the pending word. An event occurrence then sets its bit in the enable word. For each processor, the block reports an interrupt-pending output (pending AND enable is nonzero) and a disabled-wait output (no machine-check, external or I/O source is enabled). Every update takes effect on one clock edge, and both outputs are derived directly from the registered words.

Top module: `intc_core`

## Requirements
- R1: After reset, every pending word is 0x00000001, every enable word is 0x8000000A and the system word is 0. Bits 31, 3 and 1 of an enable word are never 0.
- R2: A rebuild (`mask_load_i`) sets the enable word to the OR of the following terms: 0x8000000A; bit 30 if the I/O enable is set; CR14 AND 0x1F000000 if the machine-check enable is set; CR0 AND 0x0000FEF0 if the external enable is set; bit 0 if the wait flag is set. The status field packs {io, mck, ext, per, wait}, with io as the MSB. The enable word changes only on a rebuild, a PER event or a CR9 load.
- R3: With `VTIMER_EN`=1 and the external enable set, bit 8 of the enable word follows CR0 bit 7. CR0 bit 8 has no effect.
- R4: During a rebuild, the PER enable bits (mask 0x00F90000) are kept if the PER-mode flag is set and are cleared otherwise.
- R5: A CR9 load replaces the PER bits of the pending word with (CR9 >> 8) AND 0x00F90000. In the same edge it clears every PER enable bit whose new pending bit is 0.
- R6: A PER event vector ORs its bits that fall in 0x00F90000 into the enable word. Its other bits are ignored.
- R7: A local set request ORs its bits that fall in 0x0000ED8A into the pending word. It also sets bit 31 only if one of those bits is currently enabled. Other bits of the request are ignored.
- R8: A local clear request clears its bits that fall in 0x8000ED8A. When set and clear hit the same bit in one cycle, the set wins.
- R9: A shared source is indexed 0..3 and maps to bit 30, 28, 6 or 9. A shared set acts only while its system bit is 0. When it acts, it sets the system bit and the source bit in every started processor, and it sets bit 31 only in those started processors where the source bit is enabled. A processor that is not started is left unchanged.
- R10: A shared clear acts only while its system bit is 1. When it acts, it clears the system bit and the source bit in every started processor.
- R11: A shared set and clear of the same source in one cycle resolve as a set.
- R12: `pend_o` is high when pending AND enable is nonzero. `dwait_o` is high when enable AND 0x5F00FFF0 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| started_i | input | NCPU | Processors that receive shared broadcasts |
| mask_load_i | input | NCPU | Rebuild request per processor |
| psw_i | input | NCPU*5 | Status control bits {io, mck, ext, per, wait} per processor |
| cr0_i | input | NCPU*32 | CR0 image per processor |
| cr14_i | input | NCPU*32 | CR14 image per processor |
| cr9_load_i | input | NCPU | CR9 load pulse per processor |
| cr9_i | input | NCPU*32 | CR9 image per processor |
| per_evt_i | input | NCPU*32 | PER event bits per processor |
| loc_set_i | input | NCPU*32 | Local source set request per processor |
| loc_clr_i | input | NCPU*32 | Local source clear request per processor |
| flt_set_i | input | 4 | Shared source set requests |
| flt_clr_i | input | 4 | Shared source clear requests |
| state_o | output | NCPU*32 | Pending words |
| mask_o | output | NCPU*32 | Enable words |
| pend_o | output | NCPU | Interrupt pending per processor |
| dwait_o | output | NCPU | Disabled wait per processor |
| sys_o | output | 32 | System word of shared sources |

## Verification
Each request is sampled on one rising edge. The pending, enable and system words show the result right after that edge, and `pend_o` and `dwait_o` follow without any further register stage. The driver therefore holds each request for exactly one edge and queues the expected words after that edge. The monitor compares them at the following falling edge, before the next request can land. Scenarios that depend on earlier state are run in a fixed order, so each expected value follows from the words the previous steps left behind.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned WORD      = 32;
  localparam int unsigned NFLT      = 4;
  localparam int unsigned PER_SHIFT = 8;
  localparam int unsigned B_INTR    = 31;

  localparam logic [WORD-1:0] S_INIT   = 32'h0000_0001;
  localparam logic [WORD-1:0] M_INIT   = 32'h8000_000A;
  localparam logic [WORD-1:0] M_IO     = 32'h4000_0000;
  localparam logic [WORD-1:0] M_MCK    = 32'h1F00_0000;
  localparam logic [WORD-1:0] M_PER    = 32'h00F9_0000;
  localparam logic [WORD-1:0] M_EXT_CR = 32'h0000_FEF0;
  localparam logic [WORD-1:0] M_EXT    = 32'h0000_FFF0;
  localparam logic [WORD-1:0] M_LOCAL  = 32'h0000_ED8A;
  localparam logic [WORD-1:0] M_CLR    = 32'h8000_ED8A;
  localparam logic [WORD-1:0] M_FLT    = 32'h5000_0240;
  localparam logic [WORD-1:0] M_OPEN   = M_MCK | M_EXT | M_IO;
  localparam int unsigned B_ITMR = 7;
  localparam int unsigned B_VTMR = 8;
  localparam int unsigned B_WAIT = 0;
  localparam int unsigned B_IO   = 30;

  typedef struct packed {
    logic io_en;
    logic mck_en;
    logic ext_en;
    logic per_mode;
    logic wait_st;
  } psw_ctl_t;

  localparam int unsigned PSWW = $bits(psw_ctl_t);

  // shared source index to bit position
  function automatic int unsigned flt_pos(input int unsigned k);
    case (k)
      0:       flt_pos = 30;
      1:       flt_pos = 28;
      2:       flt_pos = 6;
      default: flt_pos = 9;
    endcase
  endfunction
endpackage

// File: rtl/intc_mask_build.sv
module intc_mask_build
  import intc_pkg::*;
#(
  parameter bit VTIMER_EN = 1'b1
) (
  input  logic [WORD-1:0] cur_mask,
  input  logic [WORD-1:0] cr0,
  input  logic [WORD-1:0] cr14,
  input  psw_ctl_t        psw,
  output logic [WORD-1:0] new_mask
);
  logic [WORD-1:0] ext_term;

  generate
    if (VTIMER_EN) begin : g_vt
      always_comb begin
        ext_term = cr0 & M_EXT_CR;
        ext_term[B_VTMR] = cr0[B_ITMR];
      end
    end else begin : g_novt
      always_comb ext_term = cr0 & M_EXT_CR;
    end
  endgenerate

  always_comb begin
    new_mask = M_INIT;
    if (psw.io_en)    new_mask = new_mask | M_IO;
    if (psw.mck_en)   new_mask = new_mask | (cr14 & M_MCK);
    if (psw.per_mode) new_mask = new_mask | (cur_mask & M_PER);
    if (psw.ext_en)   new_mask = new_mask | ext_term;
    if (psw.wait_st)  new_mask[B_WAIT] = 1'b1;
  end
endmodule

// File: rtl/intc_float.sv
module intc_float
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] set_req,
  input  logic [NFLT-1:0] clr_req,
  output logic [NFLT-1:0] act_set,
  output logic [NFLT-1:0] act_clr,
  output logic [WORD-1:0] sys_word
);
  logic [NFLT-1:0] sys_q, sys_n;
  logic            sys_en;

  always_comb begin
    act_set = set_req & ~sys_q;
    act_clr = clr_req & sys_q & ~set_req;
    sys_n   = (sys_q | act_set) & ~act_clr;
    sys_en  = |(act_set | act_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sys_q <= '0;
    else if (sys_en) sys_q <= sys_n;
  end

  always_comb begin
    sys_word = '0;
    for (int unsigned k = 0; k < NFLT; k++) sys_word[flt_pos(k)] = sys_q[k];
  end
endmodule

// File: rtl/intc_cpu_slice.sv
module intc_cpu_slice
  import intc_pkg::*;
#(
  parameter bit VTIMER_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            started,
  input  logic            mask_load,
  input  psw_ctl_t        psw,
  input  logic [WORD-1:0] cr0,
  input  logic [WORD-1:0] cr14,
  input  logic            cr9_load,
  input  logic [WORD-1:0] cr9,
  input  logic [WORD-1:0] per_evt,
  input  logic [WORD-1:0] loc_set,
  input  logic [WORD-1:0] loc_clr,
  input  logic [NFLT-1:0] flt_set_act,
  input  logic [NFLT-1:0] flt_clr_act,
  output logic [WORD-1:0] state_q,
  output logic [WORD-1:0] mask_q
);
  logic [WORD-1:0] built, state_n, mask_n, lset, fset;
  logic            upd;

  intc_mask_build #(.VTIMER_EN(VTIMER_EN)) u_build (
    .cur_mask (mask_q),
    .cr0      (cr0),
    .cr14     (cr14),
    .psw      (psw),
    .new_mask (built)
  );

  always_comb begin
    state_n = state_q & ~(loc_clr & M_CLR);
    fset    = '0;
    for (int unsigned k = 0; k < NFLT; k++) begin
      if (started && flt_clr_act[k]) state_n[flt_pos(k)] = 1'b0;
      if (started && flt_set_act[k]) fset[flt_pos(k)] = 1'b1;
    end
    if (cr9_load) state_n = (state_n & ~M_PER) | ((cr9 >> PER_SHIFT) & M_PER);
    lset    = loc_set & M_LOCAL;
    state_n = state_n | lset | fset;
    if (|((lset | fset) & mask_q)) state_n[B_INTR] = 1'b1;

    mask_n = mask_load ? built : mask_q;
    mask_n = mask_n | (per_evt & M_PER);
    if (cr9_load) mask_n = mask_n & (~M_PER | state_n);

    upd = mask_load | cr9_load | (|per_evt) | (|loc_set) | (|loc_clr) |
          (started & (|(flt_set_act | flt_clr_act)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_INIT;
      mask_q  <= M_INIT;
    end else if (upd) begin
      state_q <= state_n;
      mask_q  <= mask_n;
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned NCPU      = 4,
  parameter bit          VTIMER_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCPU-1:0]      started_i,
  input  logic [NCPU-1:0]      mask_load_i,
  input  logic [NCPU*5-1:0]    psw_i,
  input  logic [NCPU*32-1:0]   cr0_i,
  input  logic [NCPU*32-1:0]   cr14_i,
  input  logic [NCPU-1:0]      cr9_load_i,
  input  logic [NCPU*32-1:0]   cr9_i,
  input  logic [NCPU*32-1:0]   per_evt_i,
  input  logic [NCPU*32-1:0]   loc_set_i,
  input  logic [NCPU*32-1:0]   loc_clr_i,
  input  logic [3:0]           flt_set_i,
  input  logic [3:0]           flt_clr_i,
  output logic [NCPU*32-1:0]   state_o,
  output logic [NCPU*32-1:0]   mask_o,
  output logic [NCPU-1:0]      pend_o,
  output logic [NCPU-1:0]      dwait_o,
  output logic [31:0]          sys_o
);
  logic [NFLT-1:0] act_set, act_clr;

  intc_float u_float (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (flt_set_i),
    .clr_req  (flt_clr_i),
    .act_set  (act_set),
    .act_clr  (act_clr),
    .sys_word (sys_o)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [WORD-1:0] st, mk;

    intc_cpu_slice #(.VTIMER_EN(VTIMER_EN)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .started     (started_i[c]),
      .mask_load   (mask_load_i[c]),
      .psw         (psw_ctl_t'(psw_i[c*PSWW +: PSWW])),
      .cr0         (cr0_i[c*WORD +: WORD]),
      .cr14        (cr14_i[c*WORD +: WORD]),
      .cr9_load    (cr9_load_i[c]),
      .cr9         (cr9_i[c*WORD +: WORD]),
      .per_evt     (per_evt_i[c*WORD +: WORD]),
      .loc_set     (loc_set_i[c*WORD +: WORD]),
      .loc_clr     (loc_clr_i[c*WORD +: WORD]),
      .flt_set_act (act_set),
      .flt_clr_act (act_clr),
      .state_q     (st),
      .mask_q      (mk)
    );

    assign state_o[c*WORD +: WORD] = st;
    assign mask_o[c*WORD +: WORD]  = mk;
    assign pend_o[c]               = |(st & mk);
    assign dwait_o[c]              = ((mk & M_OPEN) == '0);
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCPU-1:0]    started_i,
  input logic [NCPU-1:0]    mask_load_i,
  input logic [NCPU-1:0]    cr9_load_i,
  input logic [NCPU*32-1:0] per_evt_i,
  input logic [NCPU*32-1:0] loc_set_i,
  input logic [NCPU*32-1:0] state_o,
  input logic [NCPU*32-1:0] mask_o,
  input logic [31:0]        sys_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R1
    mask_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o[c*32 +: 32] & M_INIT) == M_INIT);

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_load_i[c] && !cr9_load_i[c] && per_evt_i[c*32 +: 32] == '0)
      |=> $stable(mask_o[c*32 +: 32]));

    // R5
    cr9_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr9_load_i[c] |=> ((mask_o[c*32 +: 32] & M_PER & ~state_o[c*32 +: 32]) == '0));

    // R7
    loc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((loc_set_i[c*32 +: 32] & M_LOCAL) != '0)
      |=> ((state_o[c*32 +: 32] & $past(loc_set_i[c*32 +: 32] & M_LOCAL))
           == $past(loc_set_i[c*32 +: 32] & M_LOCAL)));

    // R9
    idle_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(started_i[c]) |-> $stable(state_o[c*32 +: 32] & M_FLT));

    for (genvar k = 0; k < NFLT; k++) begin : g_f
      localparam int unsigned FP = flt_pos(k);
      // R9
      flt_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sys_o[FP]) && $past(started_i[c])) |-> state_o[c*32 + FP]);
      // R10
      flt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_o[FP]) && $past(started_i[c])) |-> !state_o[c*32 + FP]);
    end
  end
endmodule

bind intc_core intc_chk #(.NCPU(NCPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .started_i   (started_i),
  .mask_load_i (mask_load_i),
  .cr9_load_i  (cr9_load_i),
  .per_evt_i   (per_evt_i),
  .loc_set_i   (loc_set_i),
  .state_o     (state_o),
  .mask_o      (mask_o),
  .sys_o       (sys_o)
);

// File: tb/sim_intc_core.sv
`timescale 1ns/1ps
module sim_intc_core;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    started_i, mask_load_i, cr9_load_i;
  logic [N*5-1:0]  psw_i;
  logic [N*32-1:0] cr0_i, cr14_i, cr9_i, per_evt_i, loc_set_i, loc_clr_i;
  logic [3:0]      flt_set_i, flt_clr_i;
  logic [N*32-1:0] state_o, mask_o;
  logic [N-1:0]    pend_o, dwait_o;
  logic [31:0]     sys_o;

  intc_core #(.NCPU(N)) u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    int          cpu;
    int          kind;
    logic [31:0] val;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  task automatic expect_v(string tag, int cpu, int kind, logic [31:0] val);
    item_t it;
    it.tag = tag; it.cpu = cpu; it.kind = kind; it.val = val;
    q.push_back(it);
  endtask

  // kind: 0 state, 1 mask, 2 pend, 3 dwait, 4 system word
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = state_o[it.cpu*32 +: 32];
        1: act = mask_o[it.cpu*32 +: 32];
        2: act = {31'b0, pend_o[it.cpu]};
        3: act = {31'b0, dwait_o[it.cpu]};
        default: act = sys_o;
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s cpu%0d kind%0d actual=%08h expected=%08h",
                 it.tag, it.cpu, it.kind, act, it.val);
      end
    end
  end

  task automatic idle_inputs();
    mask_load_i = '0; cr9_load_i = '0; per_evt_i = '0;
    loc_set_i = '0; loc_clr_i = '0; flt_set_i = '0; flt_clr_i = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic rebuild(int c, logic [4:0] psw, logic [31:0] c0, logic [31:0] c14);
    mask_load_i[c] = 1'b1;
    psw_i[c*5 +: 5] = psw;
    cr0_i[c*32 +: 32] = c0;
    cr14_i[c*32 +: 32] = c14;
  endtask

  initial begin
    rst_n = 1'b0; started_i = '0; psw_i = '0; cr0_i = '0; cr14_i = '0; cr9_i = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int c = 0; c < N; c++) begin
      expect_v("R1", c, 0, 32'h0000_0001);
      expect_v("R1", c, 1, 32'h8000_000A);
      expect_v("R12", c, 2, 32'h0);
      expect_v("R12", c, 3, 32'h1);
    end
    expect_v("R1", 0, 4, 32'h0);

    // R2: full rebuild on cpu0 {io,mck,ext,per,wait}=11101
    rebuild(0, 5'b11101, 32'h0000_FFFF, 32'hFF00_0000);
    cyc();
    expect_v("R2", 0, 1, 32'hDF00_FFFB);
    expect_v("R12", 0, 2, 32'h1);
    expect_v("R12", 0, 3, 32'h0);

    // R3: interval timer enables virtual timer; R2 ext gating on cpu2
    rebuild(1, 5'b00100, 32'h0000_0080, 32'h0);
    rebuild(2, 5'b00000, 32'h0000_FFFF, 32'hFFFF_FFFF);
    cyc();
    expect_v("R3", 1, 1, 32'h8000_018A);
    expect_v("R12", 1, 3, 32'h0);
    expect_v("R2", 2, 1, 32'h8000_000A);
    expect_v("R12", 2, 3, 32'h1);

    // R3: CR0 bit 8 has no enable of its own
    rebuild(1, 5'b00100, 32'h0000_0100, 32'h0);
    cyc();
    expect_v("R3", 1, 1, 32'h8000_000A);

    // R7: enabled vs not enabled local set; ignored bit
    loc_set_i[0*32 +: 32] = 32'h0000_0800;
    loc_set_i[2*32 +: 32] = 32'h0000_0400;
    loc_set_i[1*32 +: 32] = 32'h0000_0004;
    cyc();
    expect_v("R7", 0, 0, 32'h8000_0801);
    expect_v("R7", 2, 0, 32'h0000_0401);
    expect_v("R7", 1, 0, 32'h0000_0001);

    // R8: set wins over clear; R7 restart always enabled
    loc_set_i[2*32 +: 32] = 32'h0000_0400;
    loc_clr_i[2*32 +: 32] = 32'h0000_0400;
    loc_set_i[3*32 +: 32] = 32'h0000_0002;
    cyc();
    expect_v("R8", 2, 0, 32'h0000_0401);
    expect_v("R7", 3, 0, 32'h8000_0003);

    // R8: clears, including bit 31
    loc_clr_i[2*32 +: 32] = 32'h0000_0400;
    loc_clr_i[0*32 +: 32] = 32'h8000_0000;
    cyc();
    expect_v("R8", 2, 0, 32'h0000_0001);
    expect_v("R8", 0, 0, 32'h0000_0801);

    // R9: I/O broadcast to started cpus 0..2
    started_i = 4'b0111;
    flt_set_i = 4'b0001;
    cyc();
    expect_v("R9", 0, 0, 32'hC000_0801);
    expect_v("R9", 1, 0, 32'h4000_0001);
    expect_v("R9", 2, 0, 32'h4000_0001);
    expect_v("R9", 3, 0, 32'h8000_0003);
    expect_v("R9", 0, 4, 32'h4000_0000);

    // R9: no action while system bit already set
    started_i = 4'b1111;
    flt_set_i = 4'b0001;
    cyc();
    expect_v("R9", 3, 0, 32'h8000_0003);
    expect_v("R9", 0, 4, 32'h4000_0000);

    // R10: shared clear
    flt_clr_i = 4'b0001;
    cyc();
    expect_v("R10", 0, 0, 32'h8000_0801);
    expect_v("R10", 1, 0, 32'h0000_0001);
    expect_v("R10", 3, 0, 32'h8000_0003);
    expect_v("R10", 0, 4, 32'h0);

    // R11: set and clear of interrupt key together
    started_i = 4'b0001;
    flt_set_i = 4'b0100;
    flt_clr_i = 4'b0100;
    cyc();
    expect_v("R11", 0, 0, 32'h8000_0841);
    expect_v("R11", 1, 0, 32'h0000_0001);
    expect_v("R11", 0, 4, 32'h0000_0040);

    // R9: channel report, enabled on cpu0 only
    started_i = 4'b0011;
    flt_set_i = 4'b0010;
    cyc();
    expect_v("R9", 0, 0, 32'h9000_0841);
    expect_v("R9", 1, 0, 32'h1000_0001);
    expect_v("R9", 0, 4, 32'h1000_0040);

    // R10: clear reaches started cpu0 only
    started_i = 4'b0001;
    flt_clr_i = 4'b0010;
    cyc();
    expect_v("R10", 0, 0, 32'h8000_0841);
    expect_v("R10", 1, 0, 32'h1000_0001);
    expect_v("R10", 0, 4, 32'h0000_0040);

    // R5: CR9 load into pending word
    cr9_load_i[1] = 1'b1;
    cr9_i[1*32 +: 32] = 32'hA100_0000;
    cyc();
    expect_v("R5", 1, 0, 32'h10A1_0001);
    expect_v("R5", 1, 1, 32'h8000_000A);
    expect_v("R12", 1, 2, 32'h0);

    // R6: PER events into enable word
    per_evt_i[1*32 +: 32] = 32'hFFFF_FFFF;
    cyc();
    expect_v("R6", 1, 1, 32'h80F9_000A);
    expect_v("R12", 1, 2, 32'h1);

    // R5: reload filters enable bits
    cr9_load_i[1] = 1'b1;
    cr9_i[1*32 +: 32] = 32'h2000_0000;
    cyc();
    expect_v("R5", 1, 0, 32'h1020_0001);
    expect_v("R5", 1, 1, 32'h8020_000A);

    // R4: PER bits kept in PER mode, dropped otherwise
    rebuild(1, 5'b00010, 32'h0000_0100, 32'h0);
    cyc();
    expect_v("R4", 1, 1, 32'h8020_000A);
    rebuild(1, 5'b00000, 32'h0000_0100, 32'h0);
    cyc();
    expect_v("R4", 1, 1, 32'h8000_000A);
    expect_v("R12", 1, 3, 32'h1);
    expect_v("R12", 0, 2, 32'h1);

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule